// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block turns a set of per-channel duty values into pulse-width modulated outputs. Every channel runs at one common period. The input clock is divided by a programmable factor (prescale + 1) to form a local tick. An 8-bit counter advances on each tick and wraps every 256 ticks. Each output is high while the counter is at or below that channel's duty value. As a result, a duty value of N gives N+1 local cycles of high time, and the largest value keeps the line high for the whole period.

Software reaches the block through a 32-bit register port with a valid strobe and a write/read select.
- The channel duty words sit at the start of the map, one word per channel.
- A control word holds the global run bit and the 8-bit prescale. The prescale is split into two 4-bit fields that are not next to each other.
- A separate word holds a stored interrupt-enable flag.

Duty and prescale writes land in holding registers. They reach the comparators and the divider only at the boundary where the counter wraps from 255 to 0, so a period is never cut short or stretched. While the run bit is clear, the writes are applied at once. Clearing the run bit stops every channel together and drives every output low. Setting it restarts all channels from the first local cycle of a fresh period.

Top module: `spwm_top`

## Requirements
- R1: After reset, every output is low and every register reads back as zero.
- R2: The duty word of channel k sits at byte address 4*k. Only bits [7:0] are stored, and a read returns them in bits [7:0] with zeros above.
- R3: The control word is at byte address 0x50.
  - Bits [3:0] hold prescale bits [3:0], and bits [14:11] hold prescale bits [7:4].
  - Bit 9 is the global run bit.
  - A read returns exactly these fields, with every other bit zero.
- R4: The interrupt-enable word is at byte address 0x54. Only bit 0 is stored, and a read returns it with every other bit zero.
- R5: A read of any other address returns zero. This covers a duty word beyond the channel count, an address in the control area other than 0x50 or 0x54, and a byte address that is not a multiple of 4.
- R6: While running, each output repeats with a period of 256*(prescale+1) input clock cycles.
- R7: A duty value N below 255 gives (N+1)*(prescale+1) high cycles per period. N = 0 therefore gives one local cycle of high time.
- R8: A duty value of 255 keeps the output high without a break while the run bit is set.
- R9: While the run bit is clear, all outputs are low and the counter is held at zero.
- R10: Setting the run bit starts a new period at counter value 0. Every channel is high in its first local cycle.
- R11: A duty or prescale write made while running takes effect only from the next counter wrap. The period in progress keeps its old shape.
- R12: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the prescaler divides it |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write access, 0 = read access |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with three channels and with registered outputs selected.
- With three channels, one run drives a single-cycle pulse (duty 0), a mid-range duty and a never-low duty (255) side by side under the shared period.
- The duty word at 0x0C then falls just past the last channel, so the unmapped-read rule is tested at the true edge of the map.
- A prescale of 0x12 places set bits in both halves of the split field, so a swapped or shifted nibble changes the measured period.
- The registered-output variant adds a cycle of latency. The bench takes the restart check from the first sampled cycle after that latency.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
   // Fixed widths of the datapath
   localparam int DATA_W    = 32;
   localparam int CNT_W     = 8;
   localparam int PRE_W     = 8;
   localparam int NIB       = PRE_W / 2;

   // Register byte addresses
   localparam int CTRL_BYTE = 'h50;
   localparam int IRQ_BYTE  = 'h54;
   localparam int MAX_CH    = CTRL_BYTE / 4;

   // Control word field positions
   localparam int PLO_LSB   = 0;
   localparam int RUN_BIT   = 9;
   localparam int PHI_LSB   = 11;
   localparam int IRQ_BIT   = 0;

   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
   import spwm_pkg::*;
#(
   parameter int NUM_CH = 1,
   parameter int ADDR_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_valid,
   input  logic                    reg_write,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   input  logic                    wrap_i,
   output logic                    run_en_o,
   output logic [PRE_W-1:0]        act_pre_o,
   output logic [NUM_CH*CNT_W-1:0] act_duty_o
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BYTE);
   localparam logic [ADDR_W-1:0] IRQ_A  = ADDR_W'(IRQ_BYTE);

   logic wr_acc, rd_acc;
   logic ctrl_hit, irq_hit;
   logic shadow_ld;

   logic [NIB-1:0]   plo_q, phi_q, plo_nx, phi_nx;
   logic             run_q, run_nx;
   logic             irq_q, irq_nx;
   logic [PRE_W-1:0] act_pre_q;

   logic [NUM_CH-1:0][CNT_W-1:0] duty_flat;
   logic [DATA_W-1:0]            rd_val;
   logic                         unused_wbits;

   assign wr_acc   = reg_valid &  reg_write;
   assign rd_acc   = reg_valid & ~reg_write;
   assign ctrl_hit = (reg_addr == CTRL_A);
   assign irq_hit  = (reg_addr == IRQ_A);

   // Holding registers load from the next-state value, so a write made
   // on the wrap cycle is picked up by that same wrap.
   assign shadow_ld = wrap_i | ~run_q;

   assign unused_wbits = ^{reg_wdata[DATA_W-1:PHI_LSB+NIB],
                           reg_wdata[RUN_BIT+1], reg_wdata[CNT_W]};

   always_comb begin
      plo_nx = plo_q;
      phi_nx = phi_q;
      run_nx = run_q;
      irq_nx = irq_q;
      if (wr_acc && ctrl_hit) begin
         plo_nx = reg_wdata[PLO_LSB +: NIB];
         phi_nx = reg_wdata[PHI_LSB +: NIB];
         run_nx = reg_wdata[RUN_BIT];
      end
      if (wr_acc && irq_hit) begin
         irq_nx = reg_wdata[IRQ_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plo_q     <= '0;
         phi_q     <= '0;
         run_q     <= 1'b0;
         irq_q     <= 1'b0;
         act_pre_q <= '0;
      end else begin
         plo_q <= plo_nx;
         phi_q <= phi_nx;
         run_q <= run_nx;
         irq_q <= irq_nx;
         if (shadow_ld) begin
            act_pre_q <= {phi_nx, plo_nx};
         end
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_duty
      localparam logic [ADDR_W-1:0] DUTY_A = ADDR_W'(4 * ch);
      logic             hit;
      logic [CNT_W-1:0] duty_q, duty_nx, act_q;

      assign hit     = (reg_addr == DUTY_A);
      assign duty_nx = (wr_acc && hit) ? reg_wdata[CNT_W-1:0] : duty_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            duty_q <= '0;
            act_q  <= '0;
         end else begin
            duty_q <= duty_nx;
            if (shadow_ld) begin
               act_q <= duty_nx;
            end
         end
      end

      assign duty_flat[ch]                    = duty_q;
      assign act_duty_o[ch*CNT_W +: CNT_W] = act_q;
   end

   always_comb begin
      rd_val = '0;
      if (ctrl_hit) begin
         rd_val[PLO_LSB +: NIB] = plo_q;
         rd_val[PHI_LSB +: NIB] = phi_q;
         rd_val[RUN_BIT]        = run_q;
      end
      if (irq_hit) begin
         rd_val[IRQ_BIT] = irq_q;
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (reg_addr == ADDR_W'(4 * i)) begin
            rd_val[CNT_W-1:0] = duty_flat[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (rd_acc) begin
         reg_rdata <= rd_val;
      end
   end

   assign run_en_o  = run_q;
   assign act_pre_o = act_pre_q;
endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase
   import spwm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [PRE_W-1:0] act_pre,
   output logic [CNT_W-1:0] cnt_o,
   output logic [PRE_W-1:0] div_o,
   output logic             wrap_o
);
   logic [PRE_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign tick   = run_en && (div_q == act_pre);
   assign wrap_o = tick && (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (!run_en) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (tick) begin
         div_q <= '0;
         cnt_q <= cnt_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign div_o = div_q;
endmodule

// File: rtl/spwm_chan.sv
module spwm_chan
   import spwm_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] duty,
   output logic             pwm_o
);
   logic level;

   assign level = run_en && (cnt <= duty);

   if (OUT_REG) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= 1'b0;
         else        q <= level;
      end
      assign pwm_o = q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pwm_o      = level;
   end
endmodule

// File: rtl/spwm_top.sv
module spwm_top
   import spwm_pkg::*;
#(
   parameter int NUM_CH  = 1,
   parameter int ADDR_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("spwm_top: NUM_CH out of range");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("spwm_top: ADDR_W too narrow for the control word");
   end

   logic                    run_en;
   logic                    wrap_w;
   logic [PRE_W-1:0]        act_pre;
   logic [PRE_W-1:0]        div_w;
   logic [CNT_W-1:0]        cnt_w;
   logic [NUM_CH*CNT_W-1:0] act_duty;

   spwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_valid  (reg_valid),
      .reg_write  (reg_write),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .wrap_i     (wrap_w),
      .run_en_o   (run_en),
      .act_pre_o  (act_pre),
      .act_duty_o (act_duty)
   );

   spwm_timebase u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .act_pre (act_pre),
      .cnt_o   (cnt_w),
      .div_o   (div_w),
      .wrap_o  (wrap_w)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      spwm_chan #(.OUT_REG(OUT_REG)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .run_en (run_en),
         .cnt    (cnt_w),
         .duty   (act_duty[ch*CNT_W +: CNT_W]),
         .pwm_o  (pwm_out[ch])
      );
   end
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk
   import spwm_pkg::*;
#(
   parameter int NUM_CH = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_valid,
   input logic              reg_write,
   input logic [31:0]       reg_rdata,
   input logic [NUM_CH-1:0] pwm_out,
   input logic              run_en,
   input logic [CNT_W-1:0]  cnt,
   input logic [PRE_W-1:0]  div,
   input logic [PRE_W-1:0]  act_pre,
   input logic              wrap
);
   // R9: two cycles stopped leave every output low, for either output variant
   assert_stopped_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !$past(run_en)) |-> (pwm_out == '0));

   // R9: a stopped block holds its counter at zero
   assert_cnt_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (cnt == '0));

   // R6: the divider never passes the active prescale
   assert_div_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      div <= act_pre);

   // R6: a completed division advances the counter by one
   assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && div == act_pre) |=> (cnt == $past(cnt) + 1'b1));

   // R11: while running, the active prescale changes only at a wrap
   assert_pre_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_en) && !$past(wrap)) |-> (act_pre == $past(act_pre)));

   // R12: read data holds when no read is issued
   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_valid && !reg_write) |=> $stable(reg_rdata));
endmodule

bind spwm_top spwm_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_valid (reg_valid),
   .reg_write (reg_write),
   .reg_rdata (reg_rdata),
   .pwm_out   (pwm_out),
   .run_en    (run_en),
   .cnt       (cnt_w),
   .div       (div_w),
   .act_pre   (act_pre),
   .wrap      (wrap_w)
);

// File: tb/tb_spwm_top.sv
module tb_spwm_top;
   localparam int NCH = 3;
   localparam int LIM = 12000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH-1:0] pwm_out;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   typedef struct {
      int    ch;
      int    hi;
      int    per;
      string req;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spwm_top #(.NUM_CH(NCH), .ADDR_W(8), .OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pwm_out(pwm_out)
   );

   task automatic check_eq(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_valid = 1'b0;
      d = reg_rdata;
   endtask

   task automatic rd_check(logic [7:0] a, logic [31:0] exp, string req);
      logic [31:0] d;
      rd(a, d);
      check_eq(req, int'(d), int'(exp));
   endtask

   // Monitor side: find the next rising edge, then time the high and low runs
   task automatic measure(int ch, output int hi, output int per);
      int g = 0;
      int lo = 0;
      hi = 0;
      while (pwm_out[ch] !== 1'b0 && g < LIM) begin @(negedge clk); g++; end
      while (pwm_out[ch] !== 1'b1 && g < LIM) begin @(negedge clk); g++; end
      while (pwm_out[ch] === 1'b1 && hi < LIM) begin @(negedge clk); hi++; end
      while (pwm_out[ch] === 1'b0 && lo < LIM) begin @(negedge clk); lo++; end
      per = hi + lo;
   endtask

   task automatic push_exp(int ch, int hi, int per, string req);
      exp_t e;
      e.ch = ch; e.hi = hi; e.per = per; e.req = req;
      sb.push_back(e);
   endtask

   task automatic monitor_pop();
      exp_t e;
      int hi, per;
      e = sb.pop_front();
      measure(e.ch, hi, per);
      check_eq($sformatf("%s ch%0d high", e.req, e.ch), hi, e.hi);
      check_eq($sformatf("%s ch%0d period", e.req, e.ch), per, e.per);
   endtask

   task automatic count_lows(int ch, int n, output int lows);
      lows = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out[ch] !== 1'b1) lows++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n, t0, lows;
      logic [31:0] d;

      repeat (4) @(negedge clk);
      check_eq("R1 outputs in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 outputs after reset", int'(pwm_out), 0);
      rd_check(8'h50, 32'h0, "R1 control reset");
      rd_check(8'h04, 32'h0, "R1 duty reset");
      rd_check(8'h54, 32'h0, "R1 irq reset");

      // Register readback and decode
      wr(8'h54, 32'hFFFF_FFFF);
      rd_check(8'h54, 32'h1, "R4 irq enable set");
      wr(8'h54, 32'hFFFF_FFFE);
      rd_check(8'h54, 32'h0, "R4 irq enable clear");
      wr(8'h50, 32'hFFFF_FDFF);             // all fields set except run
      rd_check(8'h50, 32'h0000_780F, "R3 control field mask");
      wr(8'h0C, 32'h55);                    // channel 3 does not exist
      rd_check(8'h0C, 32'h0, "R5 duty beyond channel count");
      rd_check(8'h58, 32'h0, "R5 address past irq word");
      rd_check(8'h51, 32'h0, "R5 unaligned control address");
      // R12: a read strobe alone returns data on the next cycle
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 8'h50;
      @(negedge clk);
      reg_valid = 1'b0; reg_addr = 8'h00;
      check_eq("R12 read data next cycle", int'(reg_rdata), 32'h780F);
      @(negedge clk);
      check_eq("R12 read data held", int'(reg_rdata), 32'h780F);

      // Duties: 0, 100, 255 (upper bits of the write discarded)
      wr(8'h00, 32'h0000_0000);
      wr(8'h04, 32'hABCD_0064);
      wr(8'h08, 32'h0000_01FF);
      rd_check(8'h04, 32'h64, "R2 duty ch1 low byte only");
      rd_check(8'h08, 32'hFF, "R2 duty ch2 low byte only");

      // Run with prescale 0
      wr(8'h50, 32'h0000_0200);
      push_exp(0, 1, 256, "R7 duty0 pre0");
      push_exp(1, 101, 256, "R6 R7 duty100 pre0");
      while (sb.size() != 0) monitor_pop();
      count_lows(2, 700, lows);
      check_eq("R8 duty255 never low", lows, 0);

      // R11: duty change mid-period keeps the current period's shape
      measure(1, n, n);                      // align near a falling edge
      while (pwm_out[1] !== 1'b1) @(negedge clk);
      t0 = cyc;
      repeat (20) @(negedge clk);
      wr(8'h04, 32'h0000_000A);
      while (pwm_out[1] === 1'b1) @(negedge clk);
      check_eq("R11 current period keeps old duty", cyc - t0, 101);
      push_exp(1, 11, 256, "R11 new duty after wrap");
      monitor_pop();
      wr(8'h04, 32'h0000_0064);

      // R6: prescale 0x12 split as low nibble 2 and high nibble 1
      wr(8'h50, 32'h0000_0A02);
      push_exp(1, 101 * 19, 256 * 19, "R6 R7 pre 0x12 ch1");
      push_exp(0, 19, 256 * 19, "R6 R7 pre 0x12 ch0");
      while (sb.size() != 0) monitor_pop();

      // R9: stop
      wr(8'h50, 32'h0000_0802);
      repeat (2) @(negedge clk);
      n = 0;
      for (int i = 0; i < 600; i++) begin
         if (pwm_out !== '0) n++;
         @(negedge clk);
      end
      check_eq("R9 outputs low while stopped", n, 0);
      rd_check(8'h50, 32'h0000_0802, "R3 control readback split prescale");

      // R10: restart at the beginning of a period (one flop of output latency)
      wr(8'h50, 32'h0000_0A02);
      @(negedge clk);
      check_eq("R10 all channels high on restart", int'(pwm_out), 3'b111);
      n = 0;
      while (pwm_out[0] === 1'b1 && n < LIM) begin n++; @(negedge clk); end
      check_eq("R10 first period ch0 high time", n, 19);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule